// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the byte-load stream presented to a parallel non-volatile memory and recognises multi-load unlock signatures. Each signature is a chain of fixed address/data pairs. The chain selects one of several actions: arm a protected sector write, turn software write protection on or off, enter or leave identification mode, lock one of two boot blocks, or request a whole-array erase. Every load that is not part of a recognised chain is an ordinary data load. For each such load the decoder issues either a write grant or, when protection is on and no unlock prefix was given, a dummy pulse. The dummy pulse starts a busy period that writes nothing.

The program timer sits outside this block and reports the end of each program cycle on `prog_done`. Changes to protection wait for that pulse. While identification mode is active, a read address selects the manufacturer code, the device code or a boot-block lock status byte. Protection and lock flags would live in non-volatile storage in a product; here only `rst_n`, which stands for a full power cycle, clears them.

Top module: `cmdseq_decoder`

States: `ST_IDLE` (no chain in progress), `ST_K1` (first unlock byte seen), `ST_K2` (second unlock byte seen, expecting a command code), `ST_X1`/`ST_X2`/`ST_X3` (extended chain after code 80h: second AA, second 55, final code), `ST_LKSEL` (waiting for the boot-block select load), `ST_ARMED` (sector load window, left on `prog_done`). Transitions:
- The first unlock pair moves the state IDLE→K1→K2. In an extended chain it moves X1→X2→X3.
- From K2: code A0h goes to ARMED, 90h and F0h go to IDLE, and 80h goes to X1.
- From X3: code 20h goes to ARMED, 40h goes to LKSEL, and 10h goes to IDLE.
- LKSEL always returns to IDLE.
- ARMED returns to IDLE on `prog_done`.
- Any mismatching load outside ARMED returns to IDLE.

## Requirements
- R1: After reset, `prot_on`, `id_mode`, `lock_lo`, `lock_hi`, `wr_grant`, `wr_dummy` and `erase_req` are all 0.
- R2: Every chain opens with AAh loaded to 5555h and then 55h loaded to 2AAAh. A load that does not match the next expected step sends the decoder back to idle and counts as an ordinary data load. The earlier bytes of the broken chain produce no pulse.
- R3: The chain AAh@5555h, 55h@2AAAh, A0h@5555h arms a sector load. If protection was off, `prot_on` rises only in the cycle after the `prog_done` pulse that ends that armed cycle.
- R4: Each ordinary data load gives a single-cycle pulse one clock after it is captured. The pulse is `wr_grant` when `prot_on` is 0 or a sector load is armed, and `wr_dummy` otherwise.
- R5: The chain AA/55/80h/AA/55/20h (codes at 5555h, 55h at 2AAAh) arms a sector load. `prot_on` falls only after the `prog_done` pulse that ends that armed cycle.
- R6: Code 90h after the unlock pair sets `id_mode`. In that mode `id_rd_data` is 1Fh at read address 0 and A4h at read address 1. Outside the mode it is 00h.
- R7: Code F0h after the unlock pair clears `id_mode`.
- R8: In identification mode, read address 2 gives FEh when the lower block is unlocked and FFh when it is locked. An address whose bits above bit 3 are all ones and whose low nibble is 2 reports the upper block in the same way.
- R9: The chain AA/55/80h/AA/55/40h followed by a load of 00h to 0000h sets `lock_lo`. The same chain followed by FFh to 7FFFh sets `lock_hi`. Both flags stay set until reset.
- R10: The chain AA/55/80h/AA/55/10h gives a single-cycle `erase_req` pulse, but only when neither boot block is locked.
- R11: While a sector load is armed, every load is granted, including loads that look like chain steps. No chain is decoded until `prog_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power cycle |
| ld_valid | input | 1 | One-cycle byte-load strobe |
| ld_addr | input | 15 | Low address bits of the load |
| ld_data | input | 8 | Data byte of the load |
| prog_done | input | 1 | End-of-program-cycle pulse from the timer |
| rd_addr | input | 19 | Read address used in identification mode |
| wr_grant | output | 1 | Data load may program |
| wr_dummy | output | 1 | Protected load: busy cycle, nothing written |
| erase_req | output | 1 | Whole-array erase request pulse |
| prot_on | output | 1 | Software write protection active |
| id_mode | output | 1 | Identification mode active |
| lock_lo | output | 1 | Lower boot block locked |
| lock_hi | output | 1 | Upper boot block locked |
| id_rd_data | output | 8 | Identification read data |

## Verification
Pulses (`wr_grant`, `wr_dummy`, `erase_req`) and the mode flags set by a chain's last load (`id_mode`, `lock_lo`, `lock_hi`) are due one clock after the load's capturing edge. Protection changes are due one clock after the `prog_done` edge. `id_rd_data` follows `rd_addr` combinationally. The bench drives each load on a falling edge, so it is captured on the next rising edge, and samples every result on the falling edge after that, before driving the next load. It reads identification data shortly after changing `rd_addr`.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    localparam int CMD_AW = 15;
    localparam int DW     = 8;

    localparam logic [CMD_AW-1:0] ADR_KEY_A = 15'h5555;
    localparam logic [CMD_AW-1:0] ADR_KEY_B = 15'h2AAA;
    localparam logic [CMD_AW-1:0] ADR_LO    = 15'h0000;
    localparam logic [CMD_AW-1:0] ADR_HI    = 15'h7FFF;

    localparam logic [DW-1:0] DAT_KEY_A  = 8'hAA;
    localparam logic [DW-1:0] DAT_KEY_B  = 8'h55;
    localparam logic [DW-1:0] OP_ARM     = 8'hA0;
    localparam logic [DW-1:0] OP_EXT     = 8'h80;
    localparam logic [DW-1:0] OP_ID_IN   = 8'h90;
    localparam logic [DW-1:0] OP_ID_OUT  = 8'hF0;
    localparam logic [DW-1:0] OP_UNPROT  = 8'h20;
    localparam logic [DW-1:0] OP_LOCK    = 8'h40;
    localparam logic [DW-1:0] OP_ERASE   = 8'h10;
    localparam logic [DW-1:0] SEL_LO_DAT = 8'h00;
    localparam logic [DW-1:0] SEL_HI_DAT = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_X1,
        ST_X2,
        ST_X3,
        ST_LKSEL,
        ST_ARMED
    } seq_state_t;
endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
    import cmdseq_pkg::*;
(
    input  logic [CMD_AW-1:0] addr,
    input  logic [DW-1:0]     data,
    output logic              hit_key_a,
    output logic              hit_key_b,
    output logic              at_code,
    output logic              sel_lo,
    output logic              sel_hi
);
    always_comb begin
        at_code   = (addr == ADR_KEY_A);
        hit_key_a = at_code && (data == DAT_KEY_A);
        hit_key_b = (addr == ADR_KEY_B) && (data == DAT_KEY_B);
        sel_lo    = (addr == ADR_LO) && (data == SEL_LO_DAT);
        sel_hi    = (addr == ADR_HI) && (data == SEL_HI_DAT);
    end
endmodule

// File: rtl/cmdseq_modes.sv
module cmdseq_modes (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_on,
    input  logic pend_off,
    input  logic apply,
    input  logic id_on,
    input  logic id_off,
    input  logic lk_lo_set,
    input  logic lk_hi_set,
    output logic prot_on,
    output logic id_mode,
    output logic lock_lo,
    output logic lock_hi
);
    logic prot_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_pend <= 1'b0;
            prot_on   <= 1'b0;
            id_mode   <= 1'b0;
            lock_lo   <= 1'b0;
            lock_hi   <= 1'b0;
        end else begin
            if (pend_on)
                prot_pend <= 1'b1;
            else if (pend_off)
                prot_pend <= 1'b0;
            if (apply)
                prot_on <= prot_pend;
            if (id_on)
                id_mode <= 1'b1;
            else if (id_off)
                id_mode <= 1'b0;
            if (lk_lo_set)
                lock_lo <= 1'b1;
            if (lk_hi_set)
                lock_hi <= 1'b1;
        end
    end
endmodule

// File: rtl/cmdseq_id_rom.sv
module cmdseq_id_rom
    import cmdseq_pkg::*;
#(
    parameter int            ARR_AW   = 19,
    parameter logic [DW-1:0] MFR_CODE = 8'h1F,
    parameter logic [DW-1:0] DEV_CODE = 8'hA4
) (
    input  logic              id_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    localparam int UPW = ARR_AW - 4;

    logic upper_hit;
    assign upper_hit = (rd_addr[ARR_AW-1:4] == {UPW{1'b1}}) && (rd_addr[3:0] == 4'h2);

    always_comb begin
        rd_data = '0;
        if (id_mode) begin
            if (rd_addr == ARR_AW'(0))
                rd_data = MFR_CODE;
            else if (rd_addr == ARR_AW'(1))
                rd_data = DEV_CODE;
            else if (rd_addr == ARR_AW'(2))
                rd_data = {{(DW-1){1'b1}}, lock_lo};
            else if (upper_hit)
                rd_data = {{(DW-1){1'b1}}, lock_hi};
        end
    end
endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
    import cmdseq_pkg::*;
#(
    parameter int            ARR_AW   = 19,
    parameter logic [DW-1:0] MFR_CODE = 8'h1F,
    parameter logic [DW-1:0] DEV_CODE = 8'hA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [CMD_AW-1:0] ld_addr,
    input  logic [DW-1:0]     ld_data,
    input  logic              prog_done,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic              wr_grant,
    output logic              wr_dummy,
    output logic              erase_req,
    output logic              prot_on,
    output logic              id_mode,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic [DW-1:0]     id_rd_data
);
    seq_state_t state, nxt;

    logic hit_key_a, hit_key_b, at_code, sel_lo, sel_hi;
    logic take_data, pend_on, pend_off, id_on, id_off;
    logic lk_lo_set, lk_hi_set, erase_hit, apply;

    cmdseq_match u_match (
        .addr      (ld_addr),
        .data      (ld_data),
        .hit_key_a (hit_key_a),
        .hit_key_b (hit_key_b),
        .at_code   (at_code),
        .sel_lo    (sel_lo),
        .sel_hi    (sel_hi)
    );

    always_comb begin
        nxt       = state;
        take_data = 1'b0;
        pend_on   = 1'b0;
        pend_off  = 1'b0;
        id_on     = 1'b0;
        id_off    = 1'b0;
        lk_lo_set = 1'b0;
        lk_hi_set = 1'b0;
        erase_hit = 1'b0;
        if (state == ST_ARMED) begin
            take_data = ld_valid;
            if (prog_done)
                nxt = ST_IDLE;
        end else if (ld_valid) begin
            nxt = ST_IDLE;
            unique case (state)
                ST_IDLE: if (hit_key_a) nxt = ST_K1; else take_data = 1'b1;
                ST_K1:   if (hit_key_b) nxt = ST_K2; else take_data = 1'b1;
                ST_K2: begin
                    if (at_code && ld_data == OP_ARM) begin
                        nxt     = ST_ARMED;
                        pend_on = 1'b1;
                    end else if (at_code && ld_data == OP_ID_IN)
                        id_on = 1'b1;
                    else if (at_code && ld_data == OP_ID_OUT)
                        id_off = 1'b1;
                    else if (at_code && ld_data == OP_EXT)
                        nxt = ST_X1;
                    else
                        take_data = 1'b1;
                end
                ST_X1:   if (hit_key_a) nxt = ST_X2; else take_data = 1'b1;
                ST_X2:   if (hit_key_b) nxt = ST_X3; else take_data = 1'b1;
                ST_X3: begin
                    if (at_code && ld_data == OP_UNPROT) begin
                        nxt      = ST_ARMED;
                        pend_off = 1'b1;
                    end else if (at_code && ld_data == OP_LOCK)
                        nxt = ST_LKSEL;
                    else if (at_code && ld_data == OP_ERASE)
                        erase_hit = 1'b1;
                    else
                        take_data = 1'b1;
                end
                ST_LKSEL: begin
                    if (sel_lo)
                        lk_lo_set = 1'b1;
                    else if (sel_hi)
                        lk_hi_set = 1'b1;
                    else
                        take_data = 1'b1;
                end
                default: take_data = 1'b1;
            endcase
        end
    end

    assign apply = prog_done && (state == ST_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_grant  <= 1'b0;
            wr_dummy  <= 1'b0;
            erase_req <= 1'b0;
        end else begin
            wr_grant  <= take_data && ((state == ST_ARMED) || !prot_on);
            wr_dummy  <= take_data && (state != ST_ARMED) && prot_on;
            erase_req <= erase_hit && !(lock_lo || lock_hi);
        end
    end

    cmdseq_modes u_modes (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_on   (pend_on),
        .pend_off  (pend_off),
        .apply     (apply),
        .id_on     (id_on),
        .id_off    (id_off),
        .lk_lo_set (lk_lo_set),
        .lk_hi_set (lk_hi_set),
        .prot_on   (prot_on),
        .id_mode   (id_mode),
        .lock_lo   (lock_lo),
        .lock_hi   (lock_hi)
    );

    cmdseq_id_rom #(
        .ARR_AW   (ARR_AW),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_id (
        .id_mode (id_mode),
        .lock_lo (lock_lo),
        .lock_hi (lock_hi),
        .rd_addr (rd_addr),
        .rd_data (id_rd_data)
    );
endmodule

// File: rtl/cmdseq_decoder_chk.sv
module cmdseq_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_valid,
    input logic prog_done,
    input logic wr_grant,
    input logic wr_dummy,
    input logic erase_req,
    input logic prot_on,
    input logic lock_lo,
    input logic lock_hi
);
    AST_GRANT_DUMMY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_grant && wr_dummy)); // R4

    AST_DUMMY_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dummy |-> prot_on); // R4

    AST_PULSE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_grant || wr_dummy || erase_req) |-> $past(ld_valid)); // R2

    AST_PROT_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_on) |-> $past(prog_done)); // R3

    AST_LOCK_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lo |=> lock_lo); // R9

    AST_LOCK_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hi |=> lock_hi); // R9

    AST_ERASE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !(lock_lo || lock_hi)); // R10
endmodule

bind cmdseq_decoder cmdseq_decoder_chk u_chk (.*);

// File: tb/cmdseq_decoder_test.sv
module cmdseq_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [14:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        prog_done = 1'b0;
    logic [18:0] rd_addr = '0;
    logic        wr_grant, wr_dummy, erase_req, prot_on, id_mode, lock_lo, lock_hi;
    logic [7:0]  id_rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdseq_decoder uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .prog_done(prog_done), .rd_addr(rd_addr),
        .wr_grant(wr_grant), .wr_dummy(wr_dummy), .erase_req(erase_req),
        .prot_on(prot_on), .id_mode(id_mode), .lock_lo(lock_lo),
        .lock_hi(lock_hi), .id_rd_data(id_rd_data)
    );

    function automatic logic [7:0] exp_id(input logic [18:0] a, input bit idm,
                                          input bit llo, input bit lhi);
        if (!idm) return 8'h00;
        if (a == 19'd0) return 8'h1F;
        if (a == 19'd1) return 8'hA4;
        if (a == 19'd2) return llo ? 8'hFF : 8'hFE;
        if (a == 19'h7FFF2) return lhi ? 8'hFF : 8'hFE;
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one load; on return the pulses it produced are visible.
    task automatic load(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic expect_pulses(input string tag, input bit g, input bit dm, input bit er);
        check({tag, " grant"}, {31'd0, wr_grant}, {31'd0, g});
        check({tag, " dummy"}, {31'd0, wr_dummy}, {31'd0, dm});
        check({tag, " erase"}, {31'd0, erase_req}, {31'd0, er});
    endtask

    task automatic cmd3(input logic [7:0] op);
        load(15'h5555, 8'hAA); expect_pulses("R2 key1", 0, 0, 0);
        load(15'h2AAA, 8'h55); expect_pulses("R2 key2", 0, 0, 0);
        load(15'h5555, op);
    endtask

    task automatic cmd6(input logic [7:0] op);
        cmd3(8'h80); expect_pulses("R2 ext", 0, 0, 0);
        cmd3(op);
    endtask

    task automatic done_pulse;
        @(negedge clk); prog_done = 1'b1;
        @(negedge clk); prog_done = 1'b0;
    endtask

    task automatic rand_loads(input int n, input bit g, input bit dm, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [14:0] a;
            logic [7:0]  d;
            a = 15'($urandom);
            d = 8'($urandom);
            if (a == 15'h5555) a = 15'h1234;
            if (d == 8'hAA) d = 8'h3C;
            load(a, d);
            expect_pulses(tag, g, dm, 0);
        end
    endtask

    task automatic check_id(input string tag, input logic [18:0] a, input bit idm,
                            input bit llo, input bit lhi);
        rd_addr = a;
        #1;
        check(tag, {24'd0, id_rd_data}, {24'd0, exp_id(a, idm, llo, lhi)});
    endtask

    task automatic check_flags(input string tag, input bit p, input bit i, input bit l, input bit h);
        check({tag, " prot"}, {31'd0, prot_on}, {31'd0, p});
        check({tag, " id"}, {31'd0, id_mode}, {31'd0, i});
        check({tag, " lock_lo"}, {31'd0, lock_lo}, {31'd0, l});
        check({tag, " lock_hi"}, {31'd0, lock_hi}, {31'd0, h});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_flags("R1 reset", 0, 0, 0, 0);
        expect_pulses("R1 reset", 0, 0, 0);
        rst_n = 1'b1;

        rand_loads(20, 1, 0, "R4 unprotected data");

        // R2: broken chain, breaking load is data; decoder back in idle
        load(15'h5555, 8'hAA); expect_pulses("R2 first key", 0, 0, 0);
        load(15'h3333, 8'h12); expect_pulses("R2 mismatch as data", 1, 0, 0);
        load(15'h5555, 8'hAA);
        load(15'h5555, 8'hAA); expect_pulses("R2 repeated key as data", 1, 0, 0);

        // R6/R8/R7: identification mode
        check_id("R6 id off reads zero", 19'd0, 0, 0, 0);
        cmd3(8'h90);
        check_flags("R6 id enter", 0, 1, 0, 0);
        check_id("R6 mfr", 19'd0, 1, 0, 0);
        check_id("R6 dev", 19'd1, 1, 0, 0);
        check_id("R8 lower open", 19'd2, 1, 0, 0);
        check_id("R8 upper open", 19'h7FFF2, 1, 0, 0);
        cmd3(8'hF0);
        check_flags("R7 id exit", 0, 0, 0, 0);
        check_id("R7 id off reads zero", 19'd1, 0, 0, 0);

        // R10: erase while unlocked
        cmd6(8'h10);
        expect_pulses("R10 erase unlocked", 0, 0, 1);
        @(negedge clk);
        check("R10 erase single cycle", {31'd0, erase_req}, 32'd0);

        // R3/R11: enable protection
        cmd3(8'hA0);
        expect_pulses("R3 arm", 0, 0, 0);
        rand_loads(5, 1, 0, "R11 armed data");
        load(15'h5555, 8'hAA); expect_pulses("R11 key while armed", 1, 0, 0);
        load(15'h2AAA, 8'h55); expect_pulses("R11 key2 while armed", 1, 0, 0);
        check("R3 prot pending", {31'd0, prot_on}, 32'd0);
        done_pulse();
        check("R3 prot after done", {31'd0, prot_on}, 32'd1);

        // R4: protected loads are dummies
        rand_loads(30, 0, 1, "R4 protected dummy");
        done_pulse();
        check("R4 stray done keeps prot", {31'd0, prot_on}, 32'd1);
        cmd3(8'hA0);
        rand_loads(8, 1, 0, "R4 prefixed grant");
        done_pulse();
        check("R4 prot stays after prefixed write", {31'd0, prot_on}, 32'd1);
        rand_loads(3, 0, 1, "R4 prefix consumed");

        // R5: disable protection
        cmd6(8'h20);
        expect_pulses("R5 arm", 0, 0, 0);
        rand_loads(4, 1, 0, "R5 armed data");
        check("R5 prot before done", {31'd0, prot_on}, 32'd1);
        done_pulse();
        check("R5 prot after done", {31'd0, prot_on}, 32'd0);
        rand_loads(5, 1, 0, "R5 unprotected again");

        // R9: lock lower block
        cmd6(8'h40);
        expect_pulses("R9 lock chain", 0, 0, 0);
        load(15'h0000, 8'h00);
        expect_pulses("R9 select lower", 0, 0, 0);
        check_flags("R9 lower locked", 0, 0, 1, 0);
        cmd3(8'h90);
        check_id("R8 lower locked", 19'd2, 1, 1, 0);
        check_id("R8 upper still open", 19'h7FFF2, 1, 1, 0);
        cmd3(8'hF0);

        // R10: erase suppressed
        cmd6(8'h10);
        expect_pulses("R10 erase blocked", 0, 0, 0);

        // R9: bad select is data, then upper lock
        cmd6(8'h40);
        load(15'h0001, 8'h00);
        expect_pulses("R9 bad select as data", 1, 0, 0);
        check_flags("R9 bad select no lock", 0, 0, 1, 0);
        cmd6(8'h40);
        load(15'h7FFF, 8'hFF);
        check_flags("R9 upper locked", 0, 0, 1, 1);
        rand_loads(10, 1, 0, "R9 locks sticky traffic");
        check_flags("R9 locks sticky", 0, 0, 1, 1);
        cmd3(8'h90);
        check_id("R8 upper locked", 19'h7FFF2, 1, 1, 1);
        check_id("R6 other addr zero", 19'h00123, 1, 1, 1);

        // R1: power cycle clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_flags("R1 power cycle", 0, 0, 0, 0);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule